// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block is a chain of storage stages, eight by default, that converts a parallel word into a serial bit stream. It can also pass a serial stream through. A mode select picks the action taken at each rising edge of the system clock:

- **Load:** all parallel inputs are captured into the stages at once.
- **Shift:** the serial input enters the first stage and every stage hands its bit to its neighbour toward the last stage.

The only data output is the last stage. After a load, that output presents the word most-significant stage first, one bit per clock.

A hold input freezes the register while the system clock keeps running, so a controller can pause the stream without stopping the clock. An active-low clear empties every stage at once, whatever the clock is doing, and wins over every other input. The clear is applied without waiting for the clock. Its release passes through a short synchronizer, so the register starts acting on a known edge.

Top module: `pts_shift_reg`

## Requirements
- R1: While `clr_n` is low, every stage is zero and `ser_out` is 0; a falling `clr_n` clears the register without waiting for a clock edge.
- R2: While `clr_n` is low, clock edges neither load nor shift, whatever `hold`, `mode_shift` and the data inputs are.
- R3: With `hold` low and `mode_shift` = 1, each rising edge moves stage i into stage i+1 and `ser_in` into stage 0.
- R4: With `hold` low and `mode_shift` = 0, a rising edge copies `par_in[i]` into stage i for every i; `par_in[0]` is the first stage (a) and `par_in[WIDTH-1]` the last (h).
- R5: During a load, `ser_in` has no effect: the value in stage 0 comes from `par_in[0]` only, and `par_in` is likewise ignored while shifting.
- R6: While `hold` is high, rising edges leave every stage and `ser_out` unchanged, in either mode.
- R7: `ser_out` is the last stage; after a load followed by shifts it presents h, g, … down to a, then the serial input bits in the order they entered.
- R8: A bit presented at `ser_in` appears on `ser_out` after exactly WIDTH shift edges, and not before.
- R9: After `clr_n` rises, the register ignores the first SYNC_STAGES rising edges and acts on the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| hold | input | 1 | Clock inhibit: high freezes the register |
| mode_shift | input | 1 | 1 = serial shift, 0 = parallel load |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel load data, bit i to stage i |
| ser_out | output | 1 | Content of the last stage |

## Verification
The bench builds the block with WIDTH = 8 and SYNC_STAGES = 2. This keeps the full drain of a loaded word within a short table: eight output bits h to a, followed by the serial bits behind them. With two synchronizer stages, the release window of R9 can be observed edge by edge. A clear asserted mid-cycle over a full register exposes the asynchronous path. Holds interleaved inside a drain, in both modes, show that neither the mode select nor the data inputs leak through an inhibited edge.

// File: rtl/pts_pkg.sv
package pts_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } pts_mode_e;

endpackage

// File: rtl/pts_rst_sync.sv
module pts_rst_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic rst_sync_n
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_comb begin
                sync_d       = sync_q;
                sync_d.chain = {sync_q.chain[SYNC_STAGES-2:0], 1'b1};
            end
        end else begin : g_single
            always_comb begin
                sync_d       = sync_q;
                sync_d.chain = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rst_sync_n = sync_q.chain[SYNC_STAGES-1];

endmodule

// File: rtl/pts_shift_core.sv
module pts_shift_core
    import pts_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             mode_shift,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);

    typedef struct packed {
        logic [WIDTH-1:0] stage;
    } core_t;

    core_t            core_d, core_q;
    logic [WIDTH-1:0] shift_src;
    pts_mode_e        mode;

    assign mode = pts_mode_e'(mode_shift);

    // Source of each stage in shift mode: its predecessor, or ser_in for stage 0
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_src
            if (gi == 0) begin : g_head
                assign shift_src[gi] = ser_in;
            end else begin : g_body
                assign shift_src[gi] = core_q.stage[gi-1];
            end
        end
    endgenerate

    always_comb begin
        core_d = core_q;
        if (!hold) begin
            case (mode)
                MODE_SHIFT: core_d.stage = shift_src;
                default:    core_d.stage = par_in;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign stage_q = core_q.stage;

endmodule

// File: rtl/pts_shift_reg.sv
module pts_shift_reg #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             hold,
    input  logic             mode_shift,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    logic             rst_sync_n;
    logic [WIDTH-1:0] stage_q;

    pts_rst_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) rst_sync_i (
        .clk       (clk),
        .clr_n     (clr_n),
        .rst_sync_n(rst_sync_n)
    );

    pts_shift_core #(
        .WIDTH(WIDTH)
    ) core_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .hold      (hold),
        .mode_shift(mode_shift),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .stage_q   (stage_q)
    );

    assign ser_out = stage_q[LAST];

endmodule

// File: rtl/pts_shift_reg_chk.sv
module pts_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             rst_sync_n,
    input logic             hold,
    input logic             mode_shift,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stage,
    input logic             ser_out
);

    AST_CLEAR_EMPTIES: assert property (@(posedge clk)
        !clr_n |-> (stage == '0 && ser_out == 1'b0)); // R1

    AST_CLEAR_BLOCKS_EDGE: assert property (@(posedge clk)
        !clr_n |=> stage == '0); // R2

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!hold && mode_shift) |=> stage == {$past(stage[WIDTH-2:0]), $past(ser_in)}); // R3

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (!hold && !mode_shift) |=> stage == $past(par_in)); // R4

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_sync_n)
        hold |=> $stable(stage)); // R6

endmodule

bind pts_shift_reg pts_shift_reg_chk #(
    .WIDTH(WIDTH)
) chk_i (
    .clk       (clk),
    .clr_n     (clr_n),
    .rst_sync_n(rst_sync_n),
    .hold      (hold),
    .mode_shift(mode_shift),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .stage     (stage_q),
    .ser_out   (ser_out)
);

// File: tb/pts_shift_reg_tb_top.sv
`timescale 1ns/1ps
module pts_shift_reg_tb_top;

    localparam int WIDTH       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int NVEC        = 15;

    // Vector layout: {mode_shift, hold, ser_in, par_in[7:0], expected ser_out}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 8'hB2, 1'b1}, // R4 R5 load, out = h
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0}, // R7 out g, s1=1
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b1}, // R7 out f, s2=1
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // R7 out e, s3=0
        {1'b1, 1'b0, 1'b1, 8'h00, 1'b0}, // R7 out d, s4=1
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R7 out c, s5=0
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // R7 out b, s6=0
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R5 out a (load ignored ser_in=1), s7=0
        {1'b1, 1'b0, 1'b1, 8'hFF, 1'b1}, // R7 R5 out s1, par ignored, s8=1
        {1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // R6 hold in load mode
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // R6 hold in shift mode
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 out s2
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R3 out s3
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // R3 out s4
        {1'b0, 1'b0, 1'b1, 8'h7F, 1'b0}  // R4 load with h=0
    };

    logic             clk = 1'b0;
    logic             clr_n = 1'b0;
    logic             hold = 1'b1;
    logic             mode_shift = 1'b0;
    logic             ser_in = 1'b0;
    logic [WIDTH-1:0] par_in = '0;
    logic             ser_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pts_shift_reg #(
        .WIDTH      (WIDTH),
        .SYNC_STAGES(SYNC_STAGES)
    ) dut_i (
        .clk       (clk),
        .clr_n     (clr_n),
        .hold      (hold),
        .mode_shift(mode_shift),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .ser_out   (ser_out)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (ser_out !== exp) begin
            n_fail++;
            $display("FAIL %s: ser_out=%b expected=%b at %0t", req, ser_out, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Release clear with hold high, then let the synchronizer settle
    task automatic release_clear();
        hold  = 1'b1;
        clr_n = 1'b1;
        repeat (SYNC_STAGES + 1) tick();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // Reset state (R1)
        #2;
        check("R1", 1'b0);
        tick();
        check("R1", 1'b0);
        release_clear();
        check("R1", 1'b0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            mode_shift = VEC[i][11];
            hold       = VEC[i][10];
            ser_in     = VEC[i][9];
            par_in     = VEC[i][8:1];
            tick();
            check("R3-table", VEC[i][0]);
        end

        // R8: single one travels WIDTH edges
        clr_n = 1'b0;
        #1;
        clr_n = 1'b1;
        release_clear();
        hold       = 1'b0;
        mode_shift = 1'b1;
        par_in     = '1;
        ser_in     = 1'b1;
        tick();
        ser_in = 1'b0;
        for (int k = 1; k < WIDTH; k++) begin
            check("R8", 1'b0);
            tick();
        end
        check("R8", 1'b1);

        // R1: asynchronous clear in mid-cycle over a full register
        mode_shift = 1'b0;
        par_in     = '1;
        tick();
        check("R4", 1'b1);
        clr_n = 1'b0;
        #1;
        check("R1", 1'b0);

        // R2: edges during clear load nothing
        hold = 1'b0;
        tick();
        check("R2", 1'b0);
        mode_shift = 1'b1;
        ser_in     = 1'b1;
        tick();
        check("R2", 1'b0);

        // R9: release with load active; first SYNC_STAGES edges ignored
        mode_shift = 1'b0;
        par_in     = '1;
        clr_n      = 1'b1;
        for (int k = 0; k < SYNC_STAGES; k++) begin
            tick();
            check("R9", 1'b0);
        end
        tick();
        check("R9", 1'b1);

        finish_run();
    end

endmodule